// File: doc/BRIEF.md
# Keyed Configuration Port Front End

This block sits on an 8-bit host I/O bus and exposes a configuration register space through two adjacent addresses: an index port and a data port. The space is hidden after reset. Software first writes an unlock key twice in a row to the index port. After that, index-port writes select a register and data-port accesses read or write the selected register. A relock key written to the index port hides the space again.

One register holds a logical device number. That number chooses which attached logical device receives accesses to the upper register indices. Those accesses go out on a simple bus: a one-hot select, a register address, write data, and a read-data return. A fixed chip identification byte can be read at its own index.

Two strap inputs pick the port pair (primary or alternate base) and the key pair (default or alternate keys). Read data comes back one cycle after the read strobe, together with a valid flag.

Top module: `cfg_port_front_end`

## Requirements
- R1: While the space is locked, data-port writes change no register and reach no device, and reads of either port return 0xFF.
- R2: Two consecutive index-port writes of the unlock key (0x87 with `key_alt_i`=0) open the space. The second write is not taken as an index, and the index reads 0x00 right after opening.
- R3: While open, an index-port write of the relock key (0xAA with `key_alt_i`=0) locks the space, and it is not taken as an index.
- R4: If the first unlock key is followed by any other index-port write, the space stays locked and two fresh unlock keys are needed.
- R5: With `key_alt_i`=1 the unlock key is 0x88 and the relock key is 0xBB. The keys 0x87 and 0xAA then act as ordinary values: 0x87 does not unlock, and 0xAA is latched as an index.
- R6: With `base_sel_i`=0 the index port is address 0x2E and the data port 0x2F. With `base_sel_i`=1 they are 0x4E and 0x4F. Accesses to any other address change nothing and return no read-valid pulse.
- R7: While open, an index-port write latches the index, and an index-port read returns it. Every read of either port returns its data with `rd_valid_o` high in the cycle after `rd_i`.
- R8: Index 0x07 is an 8-bit read/write logical device number. It resets to 0x00 and keeps its value across relocking.
- R9: Index 0x20 reads the `CHIP_ID` parameter, and writes to it are ignored.
- R10: Indices 0x30 and above go to the device whose number equals the logical device number. `dev_sel_o` is one-hot on that device, `dev_addr_o` carries the index, and read data comes from that device's byte of `dev_rdata_i`. If the number is not below `NUM_DEV`, writes are dropped and reads return 0xFF.
- R11: Any other index below 0x30 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host I/O address |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a decoded read |
| base_sel_i | input | 1 | Strap: 0 selects base 0x2E, 1 selects base 0x4E |
| key_alt_i | input | 1 | Strap: 1 selects the alternate key pair |
| dev_sel_o | output | NUM_DEV | One-hot device select for banked accesses |
| dev_addr_o | output | 8 | Register index presented to the device |
| dev_wdata_o | output | 8 | Write data to the device |
| dev_wr_o | output | 1 | Device write strobe |
| dev_rd_o | output | 1 | Device read strobe |
| dev_rdata_i | input | NUM_DEV*8 | Per-device read data, device d at bits d*8 +: 8 |

## Verification
A wrong lock state shows on the very next read of either port. It appears as 0xFF where data was expected, or as real data where 0xFF was expected. A wrong lock state can also show as a device write strobe that the bench counts but should not exist. A mis-latched index or logical device number appears as the wrong byte on the first data read after it, or as a write landing in the wrong device. A later read-back through another device's bank exposes that misplaced write. Broken key sequences and strap changes are each followed by an immediate read, so a fault surfaces within two cycles of the access that caused it.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_PRIMED, ST_OPEN} lock_st_e;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_CHIP_ID = 8'h20;
  localparam logic [7:0] IDX_BANK_LO = 8'h30;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;
endpackage

// File: rtl/cfg_port_hit.sv
module cfg_port_hit #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              base_sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              idx_wr_o,
  output logic              idx_rd_o,
  output logic              dat_wr_o,
  output logic              dat_rd_o
);
  localparam int NPORT = 2;
  logic [ADDR_W-1:0] base;
  logic [NPORT-1:0]  hit;

  assign base = base_sel_i ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign hit[p] = (addr_i == base + ADDR_W'(p));
  end

  assign idx_wr_o = hit[0] & wr_i;
  assign idx_rd_o = hit[0] & rd_i;
  assign dat_wr_o = hit[1] & wr_i;
  assign dat_rd_o = hit[1] & rd_i;

  // R6: an access decodes to at most one of the two ports
  always_comb begin
    assert_single_port_R6: assert ($onehot0({idx_wr_o | idx_rd_o, dat_wr_o | dat_rd_o}));
  end
endmodule

// File: rtl/cfg_key_lock.sv
module cfg_key_lock
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] KEY_IN_PRI  = 8'h87,
  parameter logic [7:0] KEY_OUT_PRI = 8'hAA,
  parameter logic [7:0] KEY_IN_ALT  = 8'h88,
  parameter logic [7:0] KEY_OUT_ALT = 8'hBB
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_alt_i,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic       open_entry_o,
  output logic       idx_load_o
);
  lock_st_e   state_q, state_d;
  logic [7:0] key_in, key_out;

  assign key_in  = key_alt_i ? KEY_IN_ALT  : KEY_IN_PRI;
  assign key_out = key_alt_i ? KEY_OUT_ALT : KEY_OUT_PRI;

  always_comb begin
    state_d      = state_q;
    open_entry_o = 1'b0;
    idx_load_o   = 1'b0;
    if (idx_wr_i) begin
      unique case (state_q)
        ST_LOCKED: if (wdata_i == key_in) state_d = ST_PRIMED;
        ST_PRIMED: begin
          if (wdata_i == key_in) begin
            state_d      = ST_OPEN;
            open_entry_o = 1'b1;
          end else begin
            state_d = ST_LOCKED;
          end
        end
        ST_OPEN: begin
          if (wdata_i == key_out) state_d = ST_LOCKED;
          else                    idx_load_o = 1'b1;
        end
        default: state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == ST_OPEN);

  assert_open_needs_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(idx_wr_i && wdata_i == (key_alt_i ? KEY_IN_ALT : KEY_IN_PRI)));

  assert_exit_key_locks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == key_out) |=> !open_o);

  assert_broken_seq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRIMED && idx_wr_i && wdata_i != key_in) |=> !open_o);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int         NUM_DEV = 4,
  parameter logic [7:0] CHIP_ID = 8'h5A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               open_i,
  input  logic               open_entry_i,
  input  logic               idx_load_i,
  input  logic               idx_rd_i,
  input  logic               dat_wr_i,
  input  logic               dat_rd_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               rd_valid_o,
  output logic [NUM_DEV-1:0] dev_sel_o,
  output logic [7:0]         dev_addr_o,
  output logic [7:0]         dev_wdata_o,
  output logic               dev_wr_o,
  output logic               dev_rd_o,
  input  logic [NUM_DEV*8-1:0] dev_rdata_i
);
  localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);

  logic [7:0] idx_q, ldn_q, rdata_q, rd_val, dev_byte;
  logic       rvalid_q, bank, ldn_ok, dat_acc;

  assign bank    = (idx_q >= IDX_BANK_LO);
  assign ldn_ok  = (ldn_q < NUM_DEV_B);
  assign dat_acc = open_i & bank & (dat_wr_i | dat_rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (open_entry_i)    idx_q <= 8'h00;
      else if (idx_load_i) idx_q <= wdata_i;
      if (open_i && dat_wr_i && idx_q == IDX_LDN) ldn_q <= wdata_i;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
    assign dev_sel_o[d] = dat_acc & (ldn_q == 8'(d));
  end

  assign dev_wr_o    = open_i & bank & ldn_ok & dat_wr_i;
  assign dev_rd_o    = open_i & bank & ldn_ok & dat_rd_i;
  assign dev_addr_o  = idx_q;
  assign dev_wdata_o = wdata_i;

  always_comb begin
    dev_byte = FILL_BYTE;
    for (int d = 0; d < NUM_DEV; d++)
      if (ldn_q == 8'(d)) dev_byte = dev_rdata_i[d*8 +: 8];
  end

  always_comb begin
    if (!open_i)       rd_val = FILL_BYTE;
    else if (idx_rd_i) rd_val = idx_q;
    else if (bank)     rd_val = dev_byte;
    else if (idx_q == IDX_LDN)     rd_val = ldn_q;
    else if (idx_q == IDX_CHIP_ID) rd_val = CHIP_ID;
    else               rd_val = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= idx_rd_i | dat_rd_i;
      if (idx_rd_i | dat_rd_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rvalid_q;

  assert_sel_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_sel_o));

  assert_locked_no_dev_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |-> (!dev_wr_o && !dev_rd_o && dev_sel_o == '0));

  assert_locked_reads_ff_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dat_rd_i || idx_rd_i) && !open_i) |=> (rd_valid_o && rdata_o == FILL_BYTE));

  assert_chip_id_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && dat_rd_i && idx_q == IDX_CHIP_ID) |=> rdata_o == CHIP_ID);

  assert_rd_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_rd_i || dat_rd_i) |=> rd_valid_o);
endmodule

// File: rtl/cfg_port_front_end.sv
module cfg_port_front_end #(
  parameter int         ADDR_W  = 16,
  parameter int         NUM_DEV = 4,
  parameter logic [7:0] CHIP_ID = 8'h5A
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 rd_valid_o,
  input  logic                 base_sel_i,
  input  logic                 key_alt_i,
  output logic [NUM_DEV-1:0]   dev_sel_o,
  output logic [7:0]           dev_addr_o,
  output logic [7:0]           dev_wdata_o,
  output logic                 dev_wr_o,
  output logic                 dev_rd_o,
  input  logic [NUM_DEV*8-1:0] dev_rdata_i
);
  logic idx_wr, idx_rd, dat_wr, dat_rd;
  logic open, open_entry, idx_load;

  cfg_port_hit #(.ADDR_W(ADDR_W)) u_hit (
    .addr_i(addr_i), .base_sel_i(base_sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .idx_wr_o(idx_wr), .idx_rd_o(idx_rd), .dat_wr_o(dat_wr), .dat_rd_o(dat_rd)
  );

  cfg_key_lock u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_alt_i(key_alt_i),
    .idx_wr_i(idx_wr), .wdata_i(wdata_i),
    .open_o(open), .open_entry_o(open_entry), .idx_load_o(idx_load)
  );

  cfg_reg_bank #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .open_i(open), .open_entry_i(open_entry),
    .idx_load_i(idx_load), .idx_rd_i(idx_rd), .dat_wr_i(dat_wr), .dat_rd_i(dat_rd),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rd_valid_o(rd_valid_o),
    .dev_sel_o(dev_sel_o), .dev_addr_o(dev_addr_o), .dev_wdata_o(dev_wdata_o),
    .dev_wr_o(dev_wr_o), .dev_rd_o(dev_rd_o), .dev_rdata_i(dev_rdata_i)
  );
endmodule

// File: tb/cfg_port_front_end_tb_top.sv
`timescale 1ns/1ps
module cfg_port_front_end_tb_top;
  localparam int         NUM_DEV = 4;
  localparam logic [7:0] CHIP_ID = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr = 0, rd = 0, base_sel = 0, key_alt = 0;
  logic [7:0] wdata = '0, rdata, dev_addr, dev_wdata;
  logic rd_valid, dev_wr, dev_rd;
  logic [NUM_DEV-1:0] dev_sel;
  logic [NUM_DEV*8-1:0] dev_rdata;

  int checks = 0, fails = 0, dev_wr_cnt = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] dev_mem [NUM_DEV][256];

  always #2.5 clk = ~clk;

  cfg_port_front_end #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .base_sel_i(base_sel), .key_alt_i(key_alt), .dev_sel_o(dev_sel),
    .dev_addr_o(dev_addr), .dev_wdata_o(dev_wdata), .dev_wr_o(dev_wr),
    .dev_rd_o(dev_rd), .dev_rdata_i(dev_rdata)
  );

  // device model
  initial for (int d = 0; d < NUM_DEV; d++) for (int a = 0; a < 256; a++) dev_mem[d][a] = 8'h00;
  always @(posedge clk) begin
    if (dev_wr) dev_wr_cnt <= dev_wr_cnt + 1;
    for (int d = 0; d < NUM_DEV; d++)
      if (dev_wr && dev_sel[d]) dev_mem[d][dev_addr] <= dev_wdata;
  end
  always_comb for (int d = 0; d < NUM_DEV; d++) dev_rdata[d*8 +: 8] = dev_mem[d][dev_addr];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic io_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset/locked state
    io_rd(16'h2F, 8'hFF, "R1 locked data read");
    io_rd(16'h2E, 8'hFF, "R1 locked index read");
    io_wr(16'h2F, 8'h55);
    @(negedge clk); check("R1 locked write no device", dev_wr_cnt, 0);
    // R4 broken sequences
    io_wr(16'h2E, 8'h87); io_wr(16'h2E, 8'h20);
    io_rd(16'h2F, 8'hFF, "R4 single key then index");
    io_wr(16'h2E, 8'h87); io_wr(16'h2E, 8'h55); io_wr(16'h2E, 8'h87);
    io_rd(16'h2F, 8'hFF, "R4 broken then one key");
    io_wr(16'h2E, 8'h87);
    io_rd(16'h2E, 8'h00, "R2 open, index cleared");
    // R7 / R9
    io_wr(16'h2E, 8'h20);
    io_rd(16'h2E, 8'h20, "R7 index readback");
    io_rd(16'h2F, CHIP_ID, "R9 chip id");
    io_wr(16'h2F, 8'h11);
    io_rd(16'h2F, CHIP_ID, "R9 chip id write ignored");
    // R8
    io_wr(16'h2E, 8'h07);
    io_rd(16'h2F, 8'h00, "R8 ldn reset, R1 locked write ignored");
    io_wr(16'h2F, 8'h02);
    io_rd(16'h2F, 8'h02, "R8 ldn readback");
    // R10 banked access
    io_wr(16'h2E, 8'h30); io_wr(16'h2F, 8'hA5);
    io_wr(16'h2E, 8'h07); io_wr(16'h2F, 8'h01);
    io_wr(16'h2E, 8'h30); io_wr(16'h2F, 8'h3C);
    io_rd(16'h2F, 8'h3C, "R10 dev1 readback");
    io_wr(16'h2E, 8'h07); io_wr(16'h2F, 8'h02);
    io_wr(16'h2E, 8'h30);
    io_rd(16'h2F, 8'hA5, "R10 dev2 readback");
    check("R10 device write count", dev_wr_cnt, 2);
    io_wr(16'h2E, 8'h07); io_wr(16'h2F, 8'h09);
    io_wr(16'h2E, 8'h30);
    io_rd(16'h2F, 8'hFF, "R10 unmapped ldn read");
    io_wr(16'h2F, 8'h66);
    @(negedge clk); check("R10 unmapped ldn write dropped", dev_wr_cnt, 2);
    // R11
    io_wr(16'h2E, 8'h10); io_wr(16'h2F, 8'h77);
    io_rd(16'h2F, 8'h00, "R11 low index reads zero");
    check("R11 low index no device write", dev_wr_cnt, 2);
    // R3
    io_wr(16'h2E, 8'hAA);
    io_rd(16'h2F, 8'hFF, "R3 relocked data");
    io_rd(16'h2E, 8'hFF, "R3 relocked index");
    // R5 alternate keys
    key_alt = 1;
    io_wr(16'h2E, 8'h87); io_wr(16'h2E, 8'h87);
    io_rd(16'h2F, 8'hFF, "R5 default key ignored");
    io_wr(16'h2E, 8'h88); io_wr(16'h2E, 8'h88);
    io_rd(16'h2E, 8'h00, "R5 alt key opens");
    io_wr(16'h2E, 8'hAA);
    io_rd(16'h2E, 8'hAA, "R5 default exit is index");
    io_wr(16'h2E, 8'hBB);
    io_rd(16'h2E, 8'hFF, "R5 alt exit locks");
    // R6 base select
    key_alt = 0; base_sel = 1;
    io_wr(16'h2E, 8'h87); io_wr(16'h2E, 8'h87);
    io_rd(16'h4F, 8'hFF, "R6 old base ignored");
    @(negedge clk); addr = 16'h2F; rd = 1;
    @(negedge clk); rd = 0;
    check("R6 no response off base", {31'h0, rd_valid}, 0);
    io_wr(16'h4E, 8'h87); io_wr(16'h4E, 8'h87);
    io_wr(16'h4E, 8'h07);
    io_rd(16'h4F, 8'h09, "R6 alt base, R8 ldn kept");
    io_wr(16'h4E, 8'hAA);
    repeat (3) @(negedge clk);
    check("R7 all reads answered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule